// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps, for every architectural register of an out-of-order core that retires through a reorder buffer, the last committed value, a busy flag and the tag of the youngest in-flight instruction that will write the register. During issue it resolves two source operands in the same cycle. Each operand comes back in one of three forms: the committed value, a value forwarded from a reorder-buffer entry that has already finished, or a pending tag that the reservation station must wait on. In that same cycle the table records the allocated reorder-buffer tag as the new producer of the destination register.

The reorder-buffer storage lives outside the block. For each source, the table presents the producer tag on a read port and receives back a ready bit and a value. At retirement the committing entry writes its value into the register. Busy is released only when that entry is still the register's newest producer. A mispredict flush drops every pending mapping at once.

Each register slot is a two-state machine. `SLOT_COMMITTED` means the register holds its architectural value and has no producer. `SLOT_PENDING` means a producer tag is outstanding. The transitions are as follows:
- RENAME moves COMMITTED to PENDING when an issue targets the register.
- RERENAME stays in PENDING and replaces the tag when a newer issue targets the register.
- RETIRE moves PENDING to COMMITTED when a commit whose tag matches the stored tag targets the register.
- FLUSH moves PENDING to COMMITTED on a flush.

Flush has priority over RERENAME, and RERENAME has priority over RETIRE.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register is in `SLOT_COMMITTED` with value 0, so a lookup of any register returns ready=1 and value 0.
- R2: A lookup of a register that is not busy returns ready=1, value equal to the committed value, and tag 0.
- R3: A lookup of a busy register whose reorder-buffer entry reports ready returns ready=1 and the entry's value, on either source port.
- R4: A lookup of a busy register whose reorder-buffer entry is not ready returns ready=0, tag equal to the stored producer tag, and value 0.
- R5: An issue (`iss_valid`=1) marks `iss_dst` busy with tag `iss_tag` from the next cycle. Lookups in the issuing cycle, including a source equal to the destination, see the mapping from before the issue.
- R6: A commit always writes `cmt_value` into `cmt_dst`. Busy is cleared only if the register's stored tag equals `cmt_tag`, so a commit from an older, superseded producer leaves the register pending on its newer tag.
- R7: When a commit and an issue target the same register in the same cycle, the register ends busy with the issued tag, and the commit's value is still written.
- R8: A flush makes every register not busy with tag 0 from the next cycle and keeps the committed values. An issue in the flush cycle is dropped.
- R9: Register 0 is renamed, forwarded and committed like any other register.
- R10: `rob_tag_a` and `rob_tag_b` carry the stored producer tag of the register addressed by `iss_src_a` and `iss_src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | REG_IDX_W | First source register |
| iss_src_b | input | REG_IDX_W | Second source register |
| iss_dst | input | REG_IDX_W | Destination register to rename |
| iss_tag | input | TAG_W | Reorder-buffer tag allocated to the issuing instruction |
| cmt_valid | input | 1 | An entry retires this cycle |
| cmt_dst | input | REG_IDX_W | Destination register of the retiring entry |
| cmt_tag | input | TAG_W | Tag of the retiring entry |
| cmt_value | input | DATA_W | Result of the retiring entry |
| flush | input | 1 | Mispredict flush of all pending mappings |
| rob_tag_a | output | TAG_W | Reorder-buffer read address for source A |
| rob_ready_a | input | 1 | Entry at `rob_tag_a` has its result |
| rob_value_a | input | DATA_W | Result held at `rob_tag_a` |
| rob_tag_b | output | TAG_W | Reorder-buffer read address for source B |
| rob_ready_b | input | 1 | Entry at `rob_tag_b` has its result |
| rob_value_b | input | DATA_W | Result held at `rob_tag_b` |
| opa_ready | output | 1 | Source A value is available |
| opa_value | output | DATA_W | Source A value (0 while pending) |
| opa_tag | output | TAG_W | Source A producer tag (0 when ready) |
| opb_ready | output | 1 | Source B value is available |
| opb_value | output | DATA_W | Source B value (0 while pending) |
| opb_tag | output | TAG_W | Source B producer tag (0 when ready) |

## Verification
Several behaviours are checked by assertions on every cycle, for every register slot:
- a rename leaves the slot pending on the issued tag;
- a mismatched commit leaves a pending slot pending;
- every commit lands its value;
- a flush empties the slot;
- a pending operand never carries a value.

Some behaviours only the bench scenarios can show. These are the old-mapping view of same-cycle lookups, forwarding from finished buffer entries on both ports, the issue-over-commit race, an issue dropped by a flush, and the reappearance of a stale commit's value once the flush removes the newer mapping.

// File: rtl/rst_pkg.sv
`timescale 1ns/1ps
package rst_pkg;

    // Life cycle of one architectural register's rename status.
    typedef enum logic {
        SLOT_COMMITTED = 1'b0,
        SLOT_PENDING   = 1'b1
    } slot_state_e;

    // Number of source operands resolved per issue.
    localparam int unsigned NUM_SRC_PORTS = 2;

endpackage

// File: rtl/rst_reg_slot.sv
`timescale 1ns/1ps
module rst_reg_slot
    import rst_pkg::*;
#(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              rename_hit,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              retire_hit,
    input  logic [TAG_W-1:0]  cmt_tag,
    input  logic [DATA_W-1:0] cmt_value,
    output logic              busy_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);

    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] value_q;

    // Next-state selection: flush over rerename over retire.
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            SLOT_COMMITTED: begin
                if (rename_hit && !flush) begin      // RENAME
                    state_d = SLOT_PENDING;
                    tag_d   = new_tag;
                end
            end
            SLOT_PENDING: begin
                if (flush) begin                     // FLUSH
                    state_d = SLOT_COMMITTED;
                    tag_d   = '0;
                end else if (rename_hit) begin       // RERENAME
                    tag_d   = new_tag;
                end else if (retire_hit && (cmt_tag == tag_q)) begin // RETIRE
                    state_d = SLOT_COMMITTED;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = SLOT_COMMITTED;
                tag_d   = '0;
            end
        endcase
    end

    // State and tag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_COMMITTED;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // Committed value: every retirement lands, matched or not.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (retire_hit) begin
            value_q <= cmt_value;
        end
    end

    // Outputs.
    always_comb begin
        busy_o  = (state_q == SLOT_PENDING);
        tag_o   = tag_q;
        value_o = value_q;
    end

    a_r5_rename_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rename_hit && !flush) |=> (busy_o && tag_o == $past(new_tag)));

    a_r6_stale_commit_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && retire_hit && !flush && cmt_tag != tag_o) |=> busy_o);

    a_r6_commit_value_lands: assert property (@(posedge clk) disable iff (!rst_n)
        retire_hit |=> (value_o == $past(cmt_value)));

    a_r8_flush_empties_slot: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!busy_o && tag_o == '0));

endmodule

// File: rtl/rst_operand_lookup.sv
`timescale 1ns/1ps
module rst_operand_lookup #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              src_busy,
    input  logic [TAG_W-1:0]  src_tag,
    input  logic [DATA_W-1:0] src_value,
    input  logic              rob_ready,
    input  logic [DATA_W-1:0] rob_value,
    output logic              op_ready,
    output logic [DATA_W-1:0] op_value,
    output logic [TAG_W-1:0]  op_tag
);

    // Three outcomes: committed value, forwarded value, pending tag.
    always_comb begin
        op_ready = 1'b1;
        op_value = src_value;
        op_tag   = '0;
        if (src_busy) begin
            if (rob_ready) begin
                op_value = rob_value;
            end else begin
                op_ready = 1'b0;
                op_value = '0;
                op_tag   = src_tag;
            end
        end
    end

endmodule

// File: rtl/rename_status_table.sv
`timescale 1ns/1ps
module rename_status_table
    import rst_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [REG_IDX_W-1:0] iss_src_a,
    input  logic [REG_IDX_W-1:0] iss_src_b,
    input  logic [REG_IDX_W-1:0] iss_dst,
    input  logic [TAG_W-1:0]     iss_tag,
    input  logic                 cmt_valid,
    input  logic [REG_IDX_W-1:0] cmt_dst,
    input  logic [TAG_W-1:0]     cmt_tag,
    input  logic [DATA_W-1:0]    cmt_value,
    input  logic                 flush,
    output logic [TAG_W-1:0]     rob_tag_a,
    input  logic                 rob_ready_a,
    input  logic [DATA_W-1:0]    rob_value_a,
    output logic [TAG_W-1:0]     rob_tag_b,
    input  logic                 rob_ready_b,
    input  logic [DATA_W-1:0]    rob_value_b,
    output logic                 opa_ready,
    output logic [DATA_W-1:0]    opa_value,
    output logic [TAG_W-1:0]     opa_tag,
    output logic                 opb_ready,
    output logic [DATA_W-1:0]    opb_value,
    output logic [TAG_W-1:0]     opb_tag
);

    logic              slot_busy  [NUM_REGS];
    logic [TAG_W-1:0]  slot_tag   [NUM_REGS];
    logic [DATA_W-1:0] slot_value [NUM_REGS];

    // One status machine per architectural register.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
        logic rename_hit;
        logic retire_hit;
        assign rename_hit = iss_valid && (iss_dst == REG_IDX_W'(r));
        assign retire_hit = cmt_valid && (cmt_dst == REG_IDX_W'(r));

        rst_reg_slot #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .rename_hit (rename_hit),
            .new_tag    (iss_tag),
            .retire_hit (retire_hit),
            .cmt_tag    (cmt_tag),
            .cmt_value  (cmt_value),
            .busy_o     (slot_busy[r]),
            .tag_o      (slot_tag[r]),
            .value_o    (slot_value[r])
        );
    end

    // Per-port views of the source operands.
    logic [REG_IDX_W-1:0] src_idx   [NUM_SRC_PORTS];
    logic                 rob_rdy   [NUM_SRC_PORTS];
    logic [DATA_W-1:0]    rob_val   [NUM_SRC_PORTS];
    logic                 op_rdy    [NUM_SRC_PORTS];
    logic [DATA_W-1:0]    op_val    [NUM_SRC_PORTS];
    logic [TAG_W-1:0]     op_tg     [NUM_SRC_PORTS];
    logic [TAG_W-1:0]     rd_tag    [NUM_SRC_PORTS];

    assign src_idx[0] = iss_src_a;
    assign src_idx[1] = iss_src_b;
    assign rob_rdy[0] = rob_ready_a;
    assign rob_rdy[1] = rob_ready_b;
    assign rob_val[0] = rob_value_a;
    assign rob_val[1] = rob_value_b;

    for (genvar p = 0; p < NUM_SRC_PORTS; p++) begin : g_port
        assign rd_tag[p] = slot_tag[src_idx[p]];

        rst_operand_lookup #(
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) lookup_i (
            .src_busy  (slot_busy[src_idx[p]]),
            .src_tag   (slot_tag[src_idx[p]]),
            .src_value (slot_value[src_idx[p]]),
            .rob_ready (rob_rdy[p]),
            .rob_value (rob_val[p]),
            .op_ready  (op_rdy[p]),
            .op_value  (op_val[p]),
            .op_tag    (op_tg[p])
        );
    end

    assign rob_tag_a = rd_tag[0];
    assign rob_tag_b = rd_tag[1];
    assign opa_ready = op_rdy[0];
    assign opa_value = op_val[0];
    assign opa_tag   = op_tg[0];
    assign opb_ready = op_rdy[1];
    assign opb_value = op_val[1];
    assign opb_tag   = op_tg[1];

    a_r4_pending_carries_no_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!opa_ready |-> opa_value == '0) and (!opb_ready |-> opb_value == '0));

    a_r10_pending_tag_is_read_address: assert property (@(posedge clk) disable iff (!rst_n)
        (!opa_ready |-> opa_tag == rob_tag_a) and (!opb_ready |-> opb_tag == rob_tag_b));

endmodule

// File: tb/rename_status_table_tb.sv
`timescale 1ns/1ps
module rename_status_table_tb_top;

    localparam int unsigned NREG = 32;
    localparam int unsigned TW   = 4;
    localparam int unsigned DW   = 32;
    localparam int unsigned IW   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [IW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          cmt_valid = 1'b0;
    logic [IW-1:0] cmt_dst = '0;
    logic [TW-1:0] cmt_tag = '0;
    logic [DW-1:0] cmt_value = '0;
    logic          flush = 1'b0;
    logic [TW-1:0] rob_tag_a, rob_tag_b;
    logic          rob_ready_a, rob_ready_b;
    logic [DW-1:0] rob_value_a, rob_value_b;
    logic          opa_ready, opb_ready;
    logic [DW-1:0] opa_value, opb_value;
    logic [TW-1:0] opa_tag, opb_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench-side reorder buffer contents.
    logic          rob_rdy [16];
    logic [DW-1:0] rob_val [16];

    always #2.5 clk = ~clk;

    always_comb begin
        rob_ready_a = rob_rdy[rob_tag_a];
        rob_value_a = rob_val[rob_tag_a];
        rob_ready_b = rob_rdy[rob_tag_b];
        rob_value_b = rob_val[rob_tag_b];
    end

    rename_status_table #(.NUM_REGS(NREG), .TAG_W(TW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_tag(iss_tag),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_tag(cmt_tag), .cmt_value(cmt_value),
        .flush(flush),
        .rob_tag_a(rob_tag_a), .rob_ready_a(rob_ready_a), .rob_value_a(rob_value_a),
        .rob_tag_b(rob_tag_b), .rob_ready_b(rob_ready_b), .rob_value_b(rob_value_b),
        .opa_ready(opa_ready), .opa_value(opa_value), .opa_tag(opa_tag),
        .opb_ready(opb_ready), .opb_value(opb_value), .opb_tag(opb_tag)
    );

    typedef struct packed {
        logic          iv;
        logic [IW-1:0] sa;
        logic [IW-1:0] sb;
        logic [IW-1:0] dst;
        logic [TW-1:0] itag;
        logic          cv;
        logic [IW-1:0] cdst;
        logic [TW-1:0] ctag;
        logic [DW-1:0] cval;
        logic          fl;
        logic          rw;
        logic [TW-1:0] rtag;
        logic [DW-1:0] rval;
        logic          ea_r;
        logic [DW-1:0] ea_w;
        logic          eb_r;
        logic [DW-1:0] eb_w;
    } step_t;

    // Expected word is the value when ready, the tag when pending.
    localparam int NSTEP = 15;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 5'd1, 5'd2, 5'd1, 4'd3,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h0,   1'b1, 32'h0},
        '{1'b1, 5'd1, 5'd2, 5'd2, 4'd5,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b0, 32'd3,   1'b1, 32'h0},
        '{1'b0, 5'd1, 5'd2, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b1, 4'd3,  32'h111, 1'b1, 32'h111, 1'b0, 32'd5},
        '{1'b0, 5'd1, 5'd2, 5'd0, 4'd0,  1'b1, 5'd1, 4'd3, 32'h111, 1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h111, 1'b0, 32'd5},
        '{1'b1, 5'd1, 5'd3, 5'd3, 4'd8,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h111, 1'b1, 32'h0},
        '{1'b1, 5'd3, 5'd1, 5'd3, 4'd9,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b0, 32'd8,   1'b1, 32'h111},
        '{1'b0, 5'd3, 5'd1, 5'd0, 4'd0,  1'b1, 5'd3, 4'd8, 32'h222, 1'b0, 1'b0, 4'd0,  32'h0,   1'b0, 32'd9,   1'b1, 32'h111},
        '{1'b1, 5'd3, 5'd2, 5'd2, 4'd10, 1'b1, 5'd2, 4'd5, 32'h333, 1'b0, 1'b0, 4'd0,  32'h0,   1'b0, 32'd9,   1'b0, 32'd5},
        '{1'b0, 5'd2, 5'd3, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b0, 32'd10,  1'b0, 32'd9},
        '{1'b1, 5'd2, 5'd3, 5'd4, 4'd11, 1'b0, 5'd0, 4'd0, 32'h0,   1'b1, 1'b0, 4'd0,  32'h0,   1'b0, 32'd10,  1'b0, 32'd9},
        '{1'b0, 5'd2, 5'd3, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h333, 1'b1, 32'h222},
        '{1'b0, 5'd4, 5'd0, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h0,   1'b1, 32'h0},
        '{1'b1, 5'd0, 5'd1, 5'd0, 4'd12, 1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h0,   1'b1, 32'h111},
        '{1'b0, 5'd0, 5'd5, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b1, 4'd12, 32'h444, 1'b1, 32'h444, 1'b1, 32'h0},
        '{1'b0, 5'd5, 5'd0, 5'd0, 4'd0,  1'b0, 5'd0, 4'd0, 32'h0,   1'b0, 1'b0, 4'd0,  32'h0,   1'b1, 32'h0,   1'b1, 32'h444}
    };

    // Requirement each step exercises.
    localparam string STEP_REQ [NSTEP] = '{
        "R5", "R4", "R3", "R3", "R2", "R4", "R5", "R6",
        "R7", "R8", "R8", "R8", "R9", "R9", "R3"
    };

    task automatic check(input string req, input bit ok, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_op(input string req, input logic rdy, input logic [DW-1:0] val,
                            input logic [TW-1:0] tg, input logic e_rdy,
                            input logic [DW-1:0] e_w);
        logic [DW-1:0] word;
        word = rdy ? val : DW'(tg);
        check(req, (rdy == e_rdy) && (word == e_w), {word[DW-2:0], rdy}, {e_w[DW-2:0], e_rdy});
    endtask

    task automatic idle_inputs();
        iss_valid = 1'b0;
        cmt_valid = 1'b0;
        flush     = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            rob_rdy[i] = 1'b0;
            rob_val[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of arbitrary registers.
        iss_src_a = 5'd7;
        iss_src_b = 5'd31;
        #1;
        check_op("R1", opa_ready, opa_value, opa_tag, 1'b1, '0);
        check_op("R1", opb_ready, opb_value, opb_tag, 1'b1, '0);

        // Vector walk.
        for (int s = 0; s < NSTEP; s++) begin
            @(negedge clk);
            if (STEPS[s].rw) begin
                rob_rdy[STEPS[s].rtag] = 1'b1;
                rob_val[STEPS[s].rtag] = STEPS[s].rval;
            end
            iss_valid = STEPS[s].iv;
            iss_src_a = STEPS[s].sa;
            iss_src_b = STEPS[s].sb;
            iss_dst   = STEPS[s].dst;
            iss_tag   = STEPS[s].itag;
            cmt_valid = STEPS[s].cv;
            cmt_dst   = STEPS[s].cdst;
            cmt_tag   = STEPS[s].ctag;
            cmt_value = STEPS[s].cval;
            flush     = STEPS[s].fl;
            #1;
            check_op(STEP_REQ[s], opa_ready, opa_value, opa_tag, STEPS[s].ea_r, STEPS[s].ea_w);
            check_op(STEP_REQ[s], opb_ready, opb_value, opb_tag, STEPS[s].eb_r, STEPS[s].eb_w);
        end

        // R10: read address of a pending source; r0 holds tag 12.
        @(negedge clk);
        idle_inputs();
        iss_src_a = 5'd0;
        iss_src_b = 5'd3;
        #1;
        check("R10", rob_tag_a == 4'd12, DW'(rob_tag_a), 32'd12);
        check("R10", rob_tag_b == 4'd0, DW'(rob_tag_b), 32'd0);

        // R4: pending value is zero while the entry is not ready.
        rob_rdy[12] = 1'b0;
        #1;
        check("R4", !opa_ready && opa_value == '0, opa_value, '0);

        // R1: reset mid-run clears a pending register and its value.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        iss_src_a = 5'd0;
        iss_src_b = 5'd1;
        #1;
        check_op("R1", opa_ready, opa_value, opa_tag, 1'b1, '0);
        check_op("R1", opb_ready, opb_value, opb_tag, 1'b1, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule